// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter built to take three consecutive samples every clock and return three consecutive results in the same clock. The single-sample datapath is copied once per lane. Every copy computes one output sample from its own input sample and the two samples just before it. A result therefore leaves the block at three times the clock rate, and each clock carries a whole block of three samples.

The registers between blocks are block delays: one register step moves the time index by three samples. The two samples that the first lanes of a block need from the past come from the block accepted before it. The tap weights are fixed by parameters when the block is built. Results keep full precision and are registered once before they leave the block. A strobe marks which input blocks are real samples. Blocks without the strobe are dropped and change nothing.

Top module: `pfir3_block`

## Requirements
- R1: Each output sample equals a·x(n) + b·x(n−1) + c·x(n−2), where a, b and c are the signed 16-bit parameters COEF_A, COEF_B and COEF_C and x is the stream of accepted signed 16-bit samples. It is computed exactly in 34-bit signed two's complement, with no rounding and no saturation.
- R2: Input lane i sits at `in_data[16*i +: 16]` and output lane i sits at `out_data[34*i +: 34]`, for i = 0, 1, 2. Lane 0 carries the earliest sample of a block and lane 2 the latest. Output lane i of a block is y(3k+i) for the block whose input lane i is x(3k+i).
- R3: Output lanes 0 and 1 take x(3k−1) and x(3k−2) from the previous accepted block: its lane 2 sample and its lane 1 sample.
- R4: `out_valid` is high in the clock after a clock with `in_valid` high, and low after a clock with `in_valid` low. `out_data` changes only at that registered stage.
- R5: While `in_valid` is low, the input lanes are ignored. The block history is not advanced, and `out_data` keeps its last value. The next accepted block continues the stream as though the idle clocks had not occurred.
- R6: A synchronous active-high `rst` has priority over `in_valid`. It clears the history to zero, `out_valid` to 0 and `out_data` to 0. The first block after reset treats x(3k−1) and x(3k−2) as zero.
- R7: Full-scale inputs (−32768 and 32767), combined with full-scale coefficients, give the exact sum without wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks the three input lanes as an accepted block |
| in_data | input | 48 | Three signed 16-bit samples, lane 0 in the low bits |
| out_valid | output | 1 | Marks `out_data` as a fresh block of results |
| out_data | output | 102 | Three signed 34-bit results, lane 0 in the low bits |

## Verification
A wrong history register does not affect lane 2. It appears only on lanes 0 and 1, and only in the block right after the register goes wrong. For that reason the reference model runs sample by sample across block boundaries, idle clocks and resets, and every lane is compared on every clock. An impulse in the last lane of a block, followed by a zero block, places b and c on lanes 0 and 1 one clock later. That isolates the cross-block path from the within-block path. An idle clock that wrongly advanced or wrongly cleared the history would show on the first two lanes of the next valid block, one clock after that block enters.

// File: rtl/pfir3_pkg.sv
package pfir3_pkg;

    // Default geometry of the three-lane block filter.
    localparam int DFLT_DATA_W = 16;
    localparam int DFLT_COEF_W = 16;
    localparam int DFLT_LANES  = 3;
    localparam int DFLT_TAPS   = 3;

    // Width that holds a sum of taps exact products without overflow.
    function automatic int acc_width(input int dw, input int cw, input int taps);
        return dw + cw + $clog2(taps);
    endfunction

endpackage

// File: rtl/pfir3_tap_lane.sv
// One replica of the single-sample datapath: a multiplier per tap and an adder chain.
module pfir3_tap_lane #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 3,
    parameter int OUT_W  = 34,
    parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
    input  logic [TAPS*DATA_W-1:0] win,   // tap t holds x(n-t)
    output logic [OUT_W-1:0]       y
);
    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod [TAPS];

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic signed [DATA_W-1:0] xs;
        logic signed [COEF_W-1:0] cs;
        assign xs = win[t*DATA_W +: DATA_W];
        assign cs = COEFS[t*COEF_W +: COEF_W];
        assign prod[t] = xs * cs;
    end

    always_comb begin
        y = '0;
        for (int t = 0; t < TAPS; t++) begin
            y = y + {{(OUT_W-PROD_W){prod[t][PROD_W-1]}}, prod[t]};
        end
    end

endmodule

// File: rtl/pfir3_blk_delay.sv
// Block delay: one register step moves time by LANES samples. Only the newest
// HIST samples of each block are kept, because no tap reaches further back.
module pfir3_blk_delay #(
    parameter int DATA_W = 16,
    parameter int LANES  = 3,
    parameter int HIST   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [LANES*DATA_W-1:0]  din,
    output logic [HIST*DATA_W-1:0]   dout
);
    typedef struct packed {
        logic [HIST-1:0][DATA_W-1:0] smp;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            for (int h = 0; h < HIST; h++) begin
                st_d.smp[h] = din[(LANES-HIST+h)*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.smp;

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dout)); // R5
    AST_HIST_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> dout == $past(din[LANES*DATA_W-1 -: HIST*DATA_W])); // R3
    AST_HIST_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> dout == '0); // R6

endmodule

// File: rtl/pfir3_out_stage.sv
// Registered output: lane results and their valid flag.
module pfir3_out_stage #(
    parameter int LANES = 3,
    parameter int OUT_W = 34
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [LANES*OUT_W-1:0]  y_in,
    output logic                    vld_out,
    output logic [LANES*OUT_W-1:0]  y_out
);
    typedef struct packed {
        logic                         vld;
        logic [LANES-1:0][OUT_W-1:0]  y;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = load;
        if (load) st_d.y = y_in;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign vld_out = st_q.vld;
    assign y_out   = st_q.y;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        load |=> vld_out); // R4
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !load |=> !vld_out); // R4
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(y_out)); // R5
    AST_OUT_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!vld_out && y_out == '0)); // R6

endmodule

// File: rtl/pfir3_block.sv
// Three-lane block FIR: LANES samples in and LANES results out every clock.
module pfir3_block
    import pfir3_pkg::*;
#(
    parameter int DATA_W = DFLT_DATA_W,
    parameter int COEF_W = DFLT_COEF_W,
    parameter int LANES  = DFLT_LANES,
    parameter logic signed [COEF_W-1:0] COEF_A = 16'sd3,
    parameter logic signed [COEF_W-1:0] COEF_B = -16'sd5,
    parameter logic signed [COEF_W-1:0] COEF_C = 16'sd7,
    localparam int TAPS  = DFLT_TAPS,
    localparam int HIST  = TAPS - 1,
    localparam int OUT_W = acc_width(DATA_W, COEF_W, TAPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*DATA_W-1:0] in_data,
    output logic                    out_valid,
    output logic [LANES*OUT_W-1:0]  out_data
);
    localparam int EXT_N = HIST + LANES;
    localparam logic [TAPS*COEF_W-1:0] COEF_VEC = {COEF_C, COEF_B, COEF_A};

    logic [HIST*DATA_W-1:0]  hist;
    logic [EXT_N*DATA_W-1:0] ext;      // index HIST+j holds x(3k+j)
    logic [LANES*OUT_W-1:0]  lane_y;

    assign ext = {in_data, hist};

    pfir3_blk_delay #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .HIST   (HIST)
    ) u_dly (
        .clk  (clk),
        .rst  (rst),
        .load (in_valid),
        .din  (in_data),
        .dout (hist)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [TAPS*DATA_W-1:0] win;
        for (genvar t = 0; t < TAPS; t++) begin : g_win
            assign win[t*DATA_W +: DATA_W] = ext[(HIST+i-t)*DATA_W +: DATA_W];
        end
        pfir3_tap_lane #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .TAPS   (TAPS),
            .OUT_W  (OUT_W),
            .COEFS  (COEF_VEC)
        ) u_lane (
            .win (win),
            .y   (lane_y[i*OUT_W +: OUT_W])
        );
    end

    pfir3_out_stage #(
        .LANES (LANES),
        .OUT_W (OUT_W)
    ) u_out (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .y_in    (lane_y),
        .vld_out (out_valid),
        .y_out   (out_data)
    );

endmodule

// File: tb/tb_pfir3_block.sv
module tb_pfir3_block;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int OW = 34;
    localparam int NL = 3;
    localparam logic signed [15:0] CA = -16'sd32768;
    localparam logic signed [15:0] CB = 16'sd21011;
    localparam logic signed [15:0] CC = -16'sd32767;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [NL*DW-1:0] in_data = '0;
    logic out_valid;
    logic [NL*OW-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    longint h1 = 0, h2 = 0;          // x(n-1), x(n-2) of the reference
    longint ey [NL] = '{0, 0, 0};    // expected held outputs

    always #(CLK_PERIOD/2) clk = ~clk;

    pfir3_block #(.COEF_A(CA), .COEF_B(CB), .COEF_C(CC)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint lane_out(input int i);
        logic signed [OW-1:0] v;
        v = out_data[i*OW +: OW];
        return longint'(v);
    endfunction

    // One clock: drive at negedge, let the edge pass, compare at next negedge.
    task automatic step(input bit r, input bit v, input int s0, input int s1, input int s2, input string tag);
        int s [NL];
        s[0] = s0; s[1] = s1; s[2] = s2;
        rst = r;
        in_valid = v;
        for (int i = 0; i < NL; i++) in_data[i*DW +: DW] = DW'(s[i]);
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            h1 = 0; h2 = 0;
            for (int i = 0; i < NL; i++) ey[i] = 0;
            check("R6", "out_valid after reset", longint'(out_valid), 0);
            for (int i = 0; i < NL; i++) check("R6", $sformatf("lane %0d after reset", i), lane_out(i), 0);
        end else if (v) begin
            for (int i = 0; i < NL; i++) begin
                longint x;
                x = longint'(s[i]);
                ey[i] = longint'(CA) * x + longint'(CB) * h1 + longint'(CC) * h2;
                h2 = h1; h1 = x;
            end
            check("R4", "out_valid after accepted block", longint'(out_valid), 1);
            // lanes 0 and 1 read the previous block (R3); lane 2 is wholly in-block (R2)
            check(tag == "" ? "R3" : tag, "lane 0", lane_out(0), ey[0]);
            check(tag == "" ? "R3" : tag, "lane 1", lane_out(1), ey[1]);
            check(tag == "" ? "R2" : tag, "lane 2", lane_out(2), ey[2]);
        end else begin
            check("R4", "out_valid after idle", longint'(out_valid), 0);
            for (int i = 0; i < NL; i++) check("R5", $sformatf("lane %0d held", i), lane_out(i), ey[i]);
        end
    endtask

    function automatic int rs();
        return int'($signed(16'($urandom)));
    endfunction

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 0, "");
        step(1, 1, 5, 6, 7, "");          // reset wins over in_valid (R6)

        // R1: impulse in lane 0 gives a, b, c on lanes 0..2
        step(0, 1, 1, 0, 0, "R1");
        step(0, 1, 0, 0, 0, "R1");
        // R3: impulse in lane 2 gives b, c on lanes 0, 1 of the next block
        step(0, 1, 0, 0, 1, "R3");
        step(0, 1, 0, 0, 0, "R3");
        step(0, 1, 0, 1, 0, "R3");
        step(0, 1, 0, 0, 0, "R3");
        // R2: distinct ramp checks lane order
        step(0, 1, 100, 200, 300, "R2");
        step(0, 1, -7, 11, -13, "R2");

        // R5: idle clocks with garbage on the lanes
        step(0, 0, 12345, -999, 31000, "");
        step(0, 0, -32768, 32767, 1, "");
        step(0, 1, 4, 5, 6, "R5");

        // random streams with random idle gaps
        for (int b = 0; b < 300; b++) begin
            if ($urandom_range(0, 3) == 0) step(0, 0, rs(), rs(), rs(), "");
            step(0, 1, rs(), rs(), rs(), "");
        end

        // R7: full-scale values
        step(0, 1, -32768, -32768, -32768, "R7");
        step(0, 1, -32768, -32768, -32768, "R7");
        step(0, 1, 32767, 32767, 32767, "R7");
        step(0, 1, 32767, -32768, 32767, "R7");
        step(0, 1, -32768, 32767, -32768, "R7");

        // R6: mid-stream reset, then history starts from zero
        step(1, 1, 9, 9, 9, "");
        step(0, 1, 1000, -2000, 3000, "R6");
        step(0, 1, rs(), rs(), rs(), "R6");

        for (int b = 0; b < 100; b++) step(0, 1, rs(), rs(), rs(), "");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule